// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block runs external memory cycles for a small 8-bit processor core. The core asks for one byte access at a time. Each request carries a 16-bit address, a space bit that selects program or data memory, a direction bit, a write byte and a wait-state count. The block answers with a one-clock completion pulse and, for reads, the byte it captured. On the pin side, one 8-bit bidirectional port first carries the low address byte and then carries data. A second 8-bit port carries the high address byte. An address-latch pulse tells an external latch when to capture the low byte. Three active-low strobes select program read, data read or data write.

Program and data memory are two separate 64 KB spaces. The same number in each space is a different location, and only the strobe tells them apart. When the internal-ROM enable input is high, program fetches below 1000h are answered on chip and no bus cycle takes place. When it is low, every program fetch goes out to the bus.

Every cycle passes through five phases: idle, address, hold, strobe, end. The strobe phase lasts one clock more than the wait-state count, which lets slow memories be used.

Top module: `xbus_ctl`

## Requirements
- R1: After reset, `ale` is low, `psen_n`, `rd_n` and `wr_n` are high, `ad_io` is high-impedance, and `done` and `busy` are low.
- R2: An accepted request raises `ale` for exactly one clock: the clock right after the request is sampled. During that clock `ad_io` carries address bits 7:0. `hi_addr` carries address bits 15:8 from the `ale` clock through the `done` clock.
- R3: On a read, `ad_io` keeps address bits 7:0 for the one clock after `ale` falls. The port is never driven while `psen_n` or `rd_n` is low. `rdata` takes the byte present on `ad_io` in the last strobe clock and holds it until the next read.
- R4: The strobe is low for `wait_cnt`+1 clocks (`wait_cnt` 0 to 7). `done` is high for one clock, and that clock is number `wait_cnt`+4 counting the `ale` clock as 1.
- R5: Only one strobe is used per request. Program requests (`req_prog`=1) use only `psen_n`. Data reads (`req_prog`=0, `req_wr`=0) use only `rd_n`. Data writes (`req_prog`=0, `req_wr`=1) use only `wr_n`.
- R6: On a data write, `ad_io` carries `req_wdata` from the clock after `ale` until the `done` clock. The `done` clock is one clock after `wr_n` returns high.
- R7: A program-space request with `req_wr`=1 runs as a program read. `wr_n` stays high.
- R8: With `irom_en`=1, a program request below 1000h produces no `ale`, no strobe, no `done` and no `busy`. Program address 1000h and all data requests still go to the bus. With `irom_en`=0, every program request goes to the bus.
- R9: A request that arrives while `busy` is high is dropped. This includes a request in the `done` clock. Such a request never produces a second `ale`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, sampled while idle |
| req_addr | input | 16 | Access address |
| req_prog | input | 1 | 1 = program space, 0 = data space |
| req_wr | input | 1 | 1 = write (data space only) |
| req_wdata | input | 8 | Write byte |
| wait_cnt | input | 3 | Extra strobe clocks, 0 to 7 |
| irom_en | input | 1 | 1 = low 4 KB of program space served on chip |
| rdata | output | 8 | Last byte read |
| done | output | 1 | One-clock completion pulse |
| busy | output | 1 | A bus cycle is in progress |
| ad_io | inout | 8 | Low address byte, then data |
| hi_addr | output | 8 | High address byte |
| ale | output | 1 | Address latch pulse |
| psen_n | output | 1 | Program read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
The completion pulse and the sampling of a new request can fall in the same clock. In the `done` clock the core may already present its next request, and that request must not start a cycle. The bench raises `req` with a different address during the hold clock and again during the `done` clock. It then counts `ale` pulses over the following clocks and expects exactly one, whose latched byte is the first address. The same count also shows that the pulse in the `done` clock did not retrigger the sequencer.

// File: rtl/xbus_ctl.sv
module xbus_ctl #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int WSW = 3,
  parameter int IROM_BYTES = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [AW-1:0] req_addr,
  input  logic          req_prog,
  input  logic          req_wr,
  input  logic [DW-1:0] req_wdata,
  input  logic [WSW-1:0] wait_cnt,
  input  logic          irom_en,
  output logic [DW-1:0] rdata,
  output logic          done,
  output logic          busy,
  inout  wire  [DW-1:0] ad_io,
  output logic [AW-DW-1:0] hi_addr,
  output logic          ale,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n
);
  localparam logic [AW-1:0] IROM_END = AW'(IROM_BYTES);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_HOLD, S_STRB, S_END} st_t;

  st_t            st;
  logic [AW-1:0]  a_q;
  logic           prog_q, wr_q;
  logic [DW-1:0]  wd_q;
  logic [WSW-1:0] ws_q, cnt;
  logic           drv_lo;
  logic [DW-1:0]  lo_val;

  wire on_chip = req_prog && irom_en && (req_addr < IROM_END);
  wire accept  = req && (st == S_IDLE) && !on_chip;
  wire strb    = (st == S_STRB);
  wire show_a  = (st == S_ADDR) || (st == S_HOLD && !wr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      a_q    <= '0;
      prog_q <= 1'b0;
      wr_q   <= 1'b0;
      wd_q   <= '0;
      ws_q   <= '0;
      cnt    <= '0;
      rdata  <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          st     <= S_ADDR;
          a_q    <= req_addr;
          prog_q <= req_prog;
          wr_q   <= req_wr && !req_prog;
          wd_q   <= req_wdata;
          ws_q   <= wait_cnt;
        end
        S_ADDR: st <= S_HOLD;
        S_HOLD: begin
          st  <= S_STRB;
          cnt <= ws_q;
        end
        S_STRB: if (cnt == '0) begin
          st <= S_END;
          if (!wr_q) rdata <= ad_io;
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_END:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign drv_lo  = show_a || (wr_q && (st == S_HOLD || st == S_STRB || st == S_END));
  assign lo_val  = show_a ? a_q[DW-1:0] : wd_q;
  assign ad_io   = drv_lo ? lo_val : {DW{1'bz}};
  assign hi_addr = a_q[AW-1:DW];
  assign ale     = (st == S_ADDR);
  assign psen_n  = !(strb && prog_q);
  assign rd_n    = !(strb && !prog_q && !wr_q);
  assign wr_n    = !(strb && wr_q);
  assign done    = (st == S_END);
  assign busy    = (st != S_IDLE);
endmodule

// File: rtl/xbus_ctl_chk.sv
module xbus_ctl_chk #(
  parameter int HW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ale,
  input logic          psen_n,
  input logic          rd_n,
  input logic          wr_n,
  input logic          drv_lo,
  input logic [HW-1:0] hi_addr,
  input logic          done,
  input logic          busy
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!psen_n, !rd_n, !wr_n}) <= 1); // R5
  AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (psen_n && rd_n && wr_n)); // R2
  AST_ALE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale); // R2
  AST_HI_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ale) |-> $stable(hi_addr)); // R2
  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (!psen_n || !rd_n) |-> !drv_lo); // R3
  AST_WR_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> drv_lo); // R6
  AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(!psen_n || !rd_n || !wr_n)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
endmodule

bind xbus_ctl xbus_ctl_chk #(.HW(AW - DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
  .wr_n(wr_n), .drv_lo(drv_lo), .hi_addr(hi_addr), .done(done), .busy(busy)
);

// File: tb/xbus_ctl_test.sv
module xbus_ctl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, req_prog = 1'b0, req_wr = 1'b0, irom_en = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic [2:0] wait_cnt = '0;
  logic [7:0] rdata, hi_addr;
  logic done, busy, ale, psen_n, rd_n, wr_n;
  wire  [7:0] ad_io;

  int nchk = 0, nfail = 0;
  logic [7:0] dmem [256];
  logic [7:0] shadow [256];
  logic [7:0] lat = '0;

  always #5 clk = ~clk;

  xbus_ctl uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr), .req_prog(req_prog),
    .req_wr(req_wr), .req_wdata(req_wdata), .wait_cnt(wait_cnt), .irom_en(irom_en),
    .rdata(rdata), .done(done), .busy(busy), .ad_io(ad_io), .hi_addr(hi_addr),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  function automatic logic [7:0] pbyte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  wire       mdrv = !psen_n || !rd_n;
  wire [7:0] mval = !psen_n ? pbyte({hi_addr, lat}) : dmem[lat];
  assign ad_io = mdrv ? mval : 8'hzz;

  always @(negedge clk) begin
    if (ale) lat = ad_io;
    if (!wr_n) dmem[lat] = ad_io;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {prog, wr, irom_en, addr[15:0], wdata[7:0], wait[2:0]}
  localparam logic [29:0] VEC [10] = '{
    {1'b0, 1'b1, 1'b0, 16'h1234, 8'h5A, 3'd0},
    {1'b0, 1'b0, 1'b0, 16'h1234, 8'h00, 3'd2},
    {1'b1, 1'b0, 1'b0, 16'h1234, 8'h00, 3'd1},
    {1'b1, 1'b0, 1'b1, 16'h0FFF, 8'h00, 3'd0},
    {1'b1, 1'b0, 1'b1, 16'h1000, 8'h00, 3'd7},
    {1'b1, 1'b0, 1'b0, 16'h0100, 8'h00, 3'd0},
    {1'b1, 1'b1, 1'b0, 16'h2077, 8'hEE, 3'd3},
    {1'b0, 1'b1, 1'b0, 16'h8056, 8'hC3, 3'd7},
    {1'b0, 1'b0, 1'b0, 16'h8056, 8'h00, 3'd0},
    {1'b0, 1'b0, 1'b1, 16'h0FFF, 8'h00, 3'd1}
  };

  task automatic access(input logic p, w, e, input logic [15:0] a,
                        input logic [7:0] d, input logic [2:0] ws);
    int ale_n = 0, ale_at = 0, done_n = 0, done_at = 0, busy_n = 0;
    int ps = 0, rc = 0, wc = 0, hi_bad = 0;
    logic [7:0] l_a = '0, hold_lo = '0, end_lo = '0;
    logic ext = !(p && e && a < 16'h1000);
    logic wr_eff = w && !p;
    logic [7:0] exp_rd;
    @(negedge clk);
    req = 1'b1; req_prog = p; req_wr = w; irom_en = e;
    req_addr = a; req_wdata = d; wait_cnt = ws;
    for (int n = 1; n <= 14; n++) begin
      @(negedge clk);
      if (n == 1) req = 1'b0;
      if (busy) busy_n++;
      if (ale) begin ale_n++; ale_at = n; l_a = ad_io; end
      if (n == 2) hold_lo = ad_io;
      if (!psen_n) ps++;
      if (!rd_n) rc++;
      if (!wr_n) wc++;
      if (busy && hi_addr != a[15:8]) hi_bad++;
      if (done) begin done_n++; done_at = n; end_lo = ad_io; end
    end
    if (!ext) begin
      chk("R8 on-chip fetch ale count", ale_n, 0);
      chk("R8 on-chip fetch done count", done_n, 0);
      chk("R8 on-chip fetch busy clocks", busy_n, 0);
      return;
    end
    chk("R2 ale count", ale_n, 1);
    chk("R2 ale clock", ale_at, 1);
    chk("R2 low address on port", l_a, a[7:0]);
    chk("R2 high address held", hi_bad, 0);
    chk("R4 done clock", done_at, ws + 4);
    chk("R4 done pulses", done_n, 1);
    chk("R5 program strobe clocks", ps, p ? ws + 1 : 0);
    chk("R5 read strobe clocks", rc, (!p && !w) ? ws + 1 : 0);
    if (p && w) chk("R7 no write strobe on program request", wc, 0);
    else chk("R5 write strobe clocks", wc, wr_eff ? ws + 1 : 0);
    if (wr_eff) begin
      shadow[a[7:0]] = d;
      chk("R6 data in hold clock", hold_lo, d);
      chk("R6 data after write strobe", end_lo, d);
    end else begin
      exp_rd = p ? pbyte(a) : shadow[a[7:0]];
      chk("R3 address kept in hold clock", hold_lo, a[7:0]);
      chk("R3 read data", rdata, exp_rd);
    end
  endtask

  initial begin
    #2_000_000;
    nchk++; nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      dmem[i] = 8'(i) ^ 8'h3C;
      shadow[i] = 8'(i) ^ 8'h3C;
    end
    repeat (3) @(negedge clk);
    chk("R1 ale", ale, 0);
    chk("R1 strobes", {psen_n, rd_n, wr_n}, 3'b111);
    chk("R1 port released", ad_io === 8'hzz, 1);
    chk("R1 done busy", {done, busy}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", {ale, done, busy}, 3'b000);

    for (int v = 0; v < 10; v++)
      access(VEC[v][29], VEC[v][28], VEC[v][27], VEC[v][26:11], VEC[v][10:3], VEC[v][2:0]);

    access(1'b1, 1'b0, 1'b0, 16'h0FFF, 8'h00, 3'd0); // R8 same fetch goes out with enable low

    // R9: requests in hold clock and in done clock are dropped
    begin
      int ales = 0;
      logic [7:0] first = '0;
      @(negedge clk);
      req = 1'b1; req_prog = 1'b0; req_wr = 1'b0; irom_en = 1'b0;
      req_addr = 16'h1256; wait_cnt = 3'd0;
      for (int n = 1; n <= 12; n++) begin
        @(negedge clk);
        if (ale) begin ales++; if (ales == 1) first = ad_io; end
        req = 1'b0;
        if (n == 2 || n == 4) begin req = 1'b1; req_addr = 16'h4444; end
        if (done) chk("R9 done while new request presented", req, 1);
      end
      req = 1'b0;
      chk("R9 single ale", ales, 1);
      chk("R9 first address kept", first, 8'h56);
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule